// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Command Controller

This controller sits between a single-clock user port and a synchronous SRAM that moves two data words per command, one on each phase of its clock. A user presents an address, a direction, a pair of write beats and a byte-enable pair, using a valid/ready handshake. The controller turns each accepted request into one command cycle on the memory side: an active-low load strobe, a read/write line and the address. For a write it follows this with one data cycle in which both beats and their active-low byte selects are driven.

Read data comes back a fixed, parameterised number of cycles after the read command. The controller tracks every outstanding read in a shift pipeline, captures both returned beats, and presents them with a one-cycle valid pulse. The rise and fall halves of each clock are carried as separate words, so the whole block lives in one clock domain. Pad-level double-rate registers are not part of it. The memory's separate input and output buses are not shared. Even so, the controller refuses to place write data in a cycle that is reserved for returning read data. When a write would land there, it holds the write back for one cycle.

Top module: `b2s_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mem_ld_n` is 1, every bit of both byte-select words is 1, `mem_wd_en` is 0 and `rsp_valid` is 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears on the memory port for the whole next cycle: `mem_ld_n` = 0, `mem_addr` = the request address, and `mem_rw` = 1 for a read (`req_write` = 0) or `mem_rw` = 0 for a write.
- R3: In any cycle that follows an edge with no accepted request, `mem_ld_n` is 1 (deselected).
- R4: In the cycle after a write command cycle, `mem_wd_en` is 1, `mem_wd_rise` carries the request's first beat and `mem_wd_fall` carries its second beat.
- R5: In that write data cycle, `mem_bws_n_rise[i]` = NOT `req_be_rise[i]` and `mem_bws_n_fall[i]` = NOT `req_be_fall[i]`. Select i covers data bits [9i+8:9i]. A select of 1 leaves that byte of memory unchanged. In every other cycle all selects are 1.
- R6: With read latency L (default 2), the memory's `mem_q_rise`/`mem_q_fall` are sampled at the end of the Lth cycle after the read command cycle. `rsp_valid` is then 1 for exactly one cycle per read, carrying both sampled beats.
- R7: `req_ready` is 0 only when `req_write` is 1 and the write's data cycle would coincide with a read return cycle. With L = 2, this is the cycle in which a read command is on the bus. Reads and other writes are never held back.
- R8: Read requests may be accepted on consecutive clocks; each produces its own response, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (21) | Burst address |
| req_wd_rise | input | DATA_W (18) | First write beat |
| req_wd_fall | input | DATA_W (18) | Second write beat |
| req_be_rise | input | LANES (2) | Active-high byte enables for the first beat |
| req_be_fall | input | LANES (2) | Active-high byte enables for the second beat |
| rsp_valid | output | 1 | One-cycle pulse: read beats valid |
| rsp_rd_rise | output | DATA_W (18) | First returned beat |
| rsp_rd_fall | output | DATA_W (18) | Second returned beat |
| mem_ld_n | output | 1 | Active-low load strobe |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | ADDR_W (21) | Memory address |
| mem_wd_en | output | 1 | Write data cycle marker |
| mem_wd_rise | output | DATA_W (18) | Write beat for the true-clock phase |
| mem_wd_fall | output | DATA_W (18) | Write beat for the complement phase |
| mem_bws_n_rise | output | LANES (2) | Active-low byte selects, first beat |
| mem_bws_n_fall | output | LANES (2) | Active-low byte selects, second beat |
| mem_q_rise | input | DATA_W (18) | Read beat, true-clock phase |
| mem_q_fall | input | DATA_W (18) | Read beat, complement phase |

## Verification
The bench writes a write directly behind a read, which is the case where a design without the turnaround stall would drive write data in the read return cycle. That stall would show up as an extra write being accepted with no wait. It also places a write right after a write and a read right after a write. A design that stalls too eagerly would show a lost cycle there. Partial byte masks that differ between the two beats expose a design that swaps the beats or the selects. On the read side, the bench fires two reads back to back and times each response to the cycle. An off-by-one latency, a valid pulse that lasts too long, or a response lost in a shared capture register would each produce a wrong value or a missing pulse.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

  // number of byte lanes in one data word
  function automatic int lanes(input int data_w, input int lane_w);
    return data_w / lane_w;
  endfunction

  // Write data trails its command by one cycle. A write accepted now
  // lands its data at (now + 2); a read placed on the bus k cycles ago
  // returns at (now - k + rd_lat). They meet when k = rd_lat - 2.
  function automatic int clash_slot(input int rd_lat);
    return (rd_lat >= 2) ? rd_lat - 2 : 0;
  endfunction

  function automatic bit clash_possible(input int rd_lat);
    return rd_lat >= 2;
  endfunction

endpackage

// File: rtl/b2s_issue.sv
module b2s_issue #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              mem_ld_n,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cmd_rd,
  output logic              cmd_wr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ld_n <= 1'b1;
      mem_rw   <= 1'b1;
      mem_addr <= '0;
    end else begin
      mem_ld_n <= ~acc;
      if (acc) begin
        mem_rw   <= ~acc_write;
        mem_addr <= acc_addr;
      end
    end
  end

  assign cmd_rd = ~mem_ld_n &  mem_rw;
  assign cmd_wr = ~mem_ld_n & ~mem_rw;

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> mem_ld_n); // R3
  AST_CMD_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (mem_rw == !$past(acc_write))); // R2
endmodule

// File: rtl/b2s_wstage.sv
module b2s_wstage #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] wd_rise,
  input  logic [DATA_W-1:0] wd_fall,
  input  logic [LANES-1:0]  be_rise,
  input  logic [LANES-1:0]  be_fall,
  output logic              mem_wd_en,
  output logic [DATA_W-1:0] mem_wd_rise,
  output logic [DATA_W-1:0] mem_wd_fall,
  output logic [LANES-1:0]  mem_bws_n_rise,
  output logic [LANES-1:0]  mem_bws_n_fall
);
  logic              pend;
  logic [DATA_W-1:0] hold_r, hold_f;
  logic [LANES-1:0]  hold_ber, hold_bef;

  // stage 1: captured at the accepting edge (command cycle follows)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      hold_r   <= '0;
      hold_f   <= '0;
      hold_ber <= '0;
      hold_bef <= '0;
    end else begin
      pend <= cap;
      if (cap) begin
        hold_r   <= wd_rise;
        hold_f   <= wd_fall;
        hold_ber <= be_rise;
        hold_bef <= be_fall;
      end
    end
  end

  // stage 2: data cycle, one after the command cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wd_en   <= 1'b0;
      mem_wd_rise <= '0;
      mem_wd_fall <= '0;
    end else begin
      mem_wd_en <= pend;
      if (pend) begin
        mem_wd_rise <= hold_r;
        mem_wd_fall <= hold_f;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_bws_n_rise[i] <= 1'b1;
        mem_bws_n_fall[i] <= 1'b1;
      end else begin
        mem_bws_n_rise[i] <= ~(pend & hold_ber[i]);
        mem_bws_n_fall[i] <= ~(pend & hold_bef[i]);
      end
    end
  end

  AST_SELECTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wd_en |-> (&mem_bws_n_rise && &mem_bws_n_fall)); // R5
endmodule

// File: rtl/b2s_rtrack.sv
module b2s_rtrack #(
  parameter int DATA_W = 18,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic [DATA_W-1:0] mem_q_rise,
  input  logic [DATA_W-1:0] mem_q_fall,
  output logic              rd_due,
  output logic              wr_hazard,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rd_rise,
  output logic [DATA_W-1:0] rsp_rd_fall
);
  localparam int SLOT = b2s_pkg::clash_slot(RD_LAT);

  logic [RD_LAT-1:0] pipe;   // pipe[k-1]: read was on the bus k cycles ago
  logic [RD_LAT:0]   track;  // track[0]: read on the bus now

  assign track  = {pipe, cmd_rd};
  assign rd_due = pipe[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe        <= '0;
      rsp_valid   <= 1'b0;
      rsp_rd_rise <= '0;
      rsp_rd_fall <= '0;
    end else begin
      pipe      <= track[RD_LAT-1:0];
      rsp_valid <= rd_due;
      if (rd_due) begin
        rsp_rd_rise <= mem_q_rise;
        rsp_rd_fall <= mem_q_fall;
      end
    end
  end

  if (b2s_pkg::clash_possible(RD_LAT)) begin : g_clash
    assign wr_hazard = track[SLOT];
  end else begin : g_noclash
    assign wr_hazard = 1'b0;
  end

  AST_RSP_FOLLOWS_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_due |=> rsp_valid); // R6
  AST_RSP_ONLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_due)); // R6
endmodule

// File: rtl/b2s_ctrl.sv
module b2s_ctrl #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  parameter int RD_LAT = 2,
  localparam int LANES = b2s_pkg::lanes(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wd_rise,
  input  logic [DATA_W-1:0] req_wd_fall,
  input  logic [LANES-1:0]  req_be_rise,
  input  logic [LANES-1:0]  req_be_fall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rd_rise,
  output logic [DATA_W-1:0] rsp_rd_fall,
  output logic              mem_ld_n,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wd_en,
  output logic [DATA_W-1:0] mem_wd_rise,
  output logic [DATA_W-1:0] mem_wd_fall,
  output logic [LANES-1:0]  mem_bws_n_rise,
  output logic [LANES-1:0]  mem_bws_n_fall,
  input  logic [DATA_W-1:0] mem_q_rise,
  input  logic [DATA_W-1:0] mem_q_fall
);
  logic acc, acc_wr, cmd_rd, cmd_wr, rd_due, wr_hazard;

  assign req_ready = ~(req_write & wr_hazard);
  assign acc       = req_valid & req_ready;
  assign acc_wr    = acc & req_write;

  b2s_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_write(req_write),
    .acc_addr(req_addr), .mem_ld_n(mem_ld_n), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr));

  b2s_wstage #(.DATA_W(DATA_W), .LANES(LANES)) u_wstage (
    .clk(clk), .rst_n(rst_n), .cap(acc_wr),
    .wd_rise(req_wd_rise), .wd_fall(req_wd_fall),
    .be_rise(req_be_rise), .be_fall(req_be_fall),
    .mem_wd_en(mem_wd_en), .mem_wd_rise(mem_wd_rise),
    .mem_wd_fall(mem_wd_fall), .mem_bws_n_rise(mem_bws_n_rise),
    .mem_bws_n_fall(mem_bws_n_fall));

  b2s_rtrack #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rtrack (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd),
    .mem_q_rise(mem_q_rise), .mem_q_fall(mem_q_fall),
    .rd_due(rd_due), .wr_hazard(wr_hazard), .rsp_valid(rsp_valid),
    .rsp_rd_rise(rsp_rd_rise), .rsp_rd_fall(rsp_rd_fall));

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_en |-> !rd_due); // R7
  AST_WR_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> mem_wd_en); // R4
  AST_WR_DATA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_en |-> $past(cmd_wr)); // R4
  AST_ADDR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!mem_ld_n && mem_addr == $past(req_addr))); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (mem_ld_n && !mem_wd_en && !rsp_valid)); // R1
endmodule

// File: tb/test_b2s_ctrl.sv
module test_b2s_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic [17:0] req_wd_rise = '0, req_wd_fall = '0;
  logic [1:0]  req_be_rise = '0, req_be_fall = '0;
  logic        rsp_valid, mem_ld_n, mem_rw, mem_wd_en;
  logic [17:0] rsp_rd_rise, rsp_rd_fall, mem_wd_rise, mem_wd_fall;
  logic [20:0] mem_addr;
  logic [1:0]  mem_bws_n_rise, mem_bws_n_fall;
  logic [17:0] mem_q_rise = '0, mem_q_fall = '0;

  int total = 0, bad = 0;

  b2s_ctrl i_b2s_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wd_rise(req_wd_rise),
    .req_wd_fall(req_wd_fall), .req_be_rise(req_be_rise),
    .req_be_fall(req_be_fall), .rsp_valid(rsp_valid),
    .rsp_rd_rise(rsp_rd_rise), .rsp_rd_fall(rsp_rd_fall),
    .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
    .mem_wd_en(mem_wd_en), .mem_wd_rise(mem_wd_rise),
    .mem_wd_fall(mem_wd_fall), .mem_bws_n_rise(mem_bws_n_rise),
    .mem_bws_n_fall(mem_bws_n_fall), .mem_q_rise(mem_q_rise),
    .mem_q_fall(mem_q_fall));

  // memory model: latency 2, write data one cycle after its command
  logic [17:0] m_r [16];
  logic [17:0] m_f [16];
  logic        p0v = 0, p1v = 0, p2v = 0;
  logic [3:0]  p0a = 0, p1a = 0, p2a = 0, wa = 0;
  initial for (int i = 0; i < 16; i++) begin m_r[i] = '0; m_f[i] = '0; end

  always @(negedge clk) begin
    if (mem_wd_en) begin
      if (!mem_bws_n_rise[0]) m_r[wa][8:0]  = mem_wd_rise[8:0];
      if (!mem_bws_n_rise[1]) m_r[wa][17:9] = mem_wd_rise[17:9];
      if (!mem_bws_n_fall[0]) m_f[wa][8:0]  = mem_wd_fall[8:0];
      if (!mem_bws_n_fall[1]) m_f[wa][17:9] = mem_wd_fall[17:9];
    end
    if (!mem_ld_n && !mem_rw) wa = mem_addr[3:0];
    p2v = p1v; p2a = p1a; p1v = p0v; p1a = p0a;
    p0v = !mem_ld_n && mem_rw; p0a = mem_addr[3:0];
    mem_q_rise = p2v ? m_r[p2a] : '0;
    mem_q_fall = p2v ? m_f[p2a] : '0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present a request at a negedge; return at negedge of its command cycle
  task automatic issue(input logic w, input logic [20:0] a, input logic [17:0] r,
                       input logic [17:0] f, input logic [1:0] br, input logic [1:0] bf,
                       output int stalls);
    stalls = 0;
    req_valid = 1; req_write = w; req_addr = a;
    req_wd_rise = r; req_wd_fall = f; req_be_rise = br; req_be_fall = bf;
    #1;
    while (!req_ready) begin stalls++; @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic t_reset;
    check("R1 ld_n", {31'd0, mem_ld_n}, 32'd1);
    check("R1 bws rise", {30'd0, mem_bws_n_rise}, 32'd3);
    check("R1 bws fall", {30'd0, mem_bws_n_fall}, 32'd3);
    check("R1 wd_en", {31'd0, mem_wd_en}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_write_full;
    int s;
    issue(1, 21'd5, 18'h2A5A5, 18'h15A5A, 2'b11, 2'b11, s);
    check("R2 wr ld_n", {31'd0, mem_ld_n}, 32'd0);
    check("R2 wr rw", {31'd0, mem_rw}, 32'd0);
    check("R2 wr addr", {11'd0, mem_addr}, 32'd5);
    @(negedge clk);
    check("R3 idle ld_n", {31'd0, mem_ld_n}, 32'd1);
    check("R4 wd_en", {31'd0, mem_wd_en}, 32'd1);
    check("R4 wd rise", {14'd0, mem_wd_rise}, 32'h2A5A5);
    check("R4 wd fall", {14'd0, mem_wd_fall}, 32'h15A5A);
    check("R5 bws rise full", {30'd0, mem_bws_n_rise}, 32'd0);
    @(negedge clk);
    check("R5 bws quiet after", {28'd0, mem_bws_n_rise, mem_bws_n_fall}, 32'hF);
  endtask

  task automatic t_read_one(input logic [20:0] a, input logic [17:0] er, input logic [17:0] ef);
    int s;
    issue(0, a, '0, '0, '0, '0, s);
    check("R2 rd rw", {31'd0, mem_rw}, 32'd1);
    check("R2 rd addr", {11'd0, mem_addr}, {11'd0, a});
    check("R7 read never stalled", s, 0);
    repeat (2) begin
      @(negedge clk);
      check("R6 early valid", {31'd0, rsp_valid}, 32'd0);
    end
    @(negedge clk);
    check("R6 valid", {31'd0, rsp_valid}, 32'd1);
    check("R6 rise beat", {14'd0, rsp_rd_rise}, {14'd0, er});
    check("R6 fall beat", {14'd0, rsp_rd_fall}, {14'd0, ef});
    @(negedge clk);
    check("R6 one-cycle pulse", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_mask;
    int s;
    issue(1, 21'd6, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11, s);
    issue(1, 21'd6, 18'h00000, 18'h00000, 2'b01, 2'b10, s);
    check("R7 write after write no stall", s, 0);
    @(negedge clk);
    check("R5 bws rise partial", {30'd0, mem_bws_n_rise}, 32'd2);
    check("R5 bws fall partial", {30'd0, mem_bws_n_fall}, 32'd1);
    @(negedge clk);
    t_read_one(21'd6, 18'h3FE00, 18'h001FF);
  endtask

  task automatic t_hazard;
    int s;
    issue(1, 21'd7, 18'h11111, 18'h22222, 2'b11, 2'b11, s);
    issue(0, 21'd5, '0, '0, '0, '0, s);
    check("R7 read after write no stall", s, 0);
    issue(1, 21'd8, 18'h0ABCD, 18'h3DCBA, 2'b11, 2'b11, s);
    check("R7 write behind read stalls one", s, 1);
    @(negedge clk);
    check("R6 read response amid write", {31'd0, rsp_valid}, 32'd1);
    check("R6 read data addr5", {14'd0, rsp_rd_rise}, 32'h2A5A5);
    check("R4 write data after stall", {31'd0, mem_wd_en}, 32'd1);
    @(negedge clk);
    t_read_one(21'd8, 18'h0ABCD, 18'h3DCBA);
  endtask

  task automatic t_back2back;
    req_valid = 1; req_write = 0; req_addr = 21'd5;
    #1 check("R8 ready for read 1", {31'd0, req_ready}, 32'd1);
    @(negedge clk); req_addr = 21'd7;
    #1 check("R8 ready for read 2", {31'd0, req_ready}, 32'd1);
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    check("R8 no early response", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    check("R8 first response", {31'd0, rsp_valid}, 32'd1);
    check("R8 first data", {14'd0, rsp_rd_fall}, 32'h15A5A);
    @(negedge clk);
    check("R8 second response", {31'd0, rsp_valid}, 32'd1);
    check("R8 second data", {14'd0, rsp_rd_rise}, 32'h11111);
    @(negedge clk);
    check("R8 responses end", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_full();
    t_read_one(21'd5, 18'h2A5A5, 18'h15A5A);
    t_mask();
    t_hazard();
    t_back2back();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule